// File: doc/BRIEF.md
# Synchronous DRAM Command Decoder with Per-Bank Legality Checking

This block watches the command pins of a synchronous DRAM interface and decodes one command on every rising clock edge. Each command is judged against the tracked state of the bank it addresses: idle, row open, or burst running. For every command the block reports three things: the decoded command code, the action it took, and a one-cycle flag when the command is illegal. Typical uses are a protocol monitor next to a memory controller and the command front end of a memory model.

Each bank has its own burst countdown. The countdown is loaded from `burst_len_i` when a read or write starts a burst. When it expires the bank drops back to row open, or to idle if address bit 10 requested auto precharge. A read or write to a bank that is already in a burst cuts that burst short and starts a new one. Precharge closes either the addressed bank or, with bit 10 high, every bank. An illegal command changes nothing at all. Every bank state and every countdown holds for that cycle.

All outputs are registered. The result for a command sampled at edge N appears just after edge N.

Top module: `sdram_cmd_checker`

## Requirements
- R1: The command code on `cmd_o` is updated at the edge that samples the pins.
  - With `cs_ni` high the code is 0 (deselect).
  - With `cs_ni` low, {ras,cas,we} decodes as: 000 → 2 (mode set), 001 → 3 (refresh), 010 → 4 (precharge), 011 → 5 (activate), 100 → 6 (write), 101 → 7 (read), 111 → 1 (no operation).
  - The unlisted pattern 110 also decodes as 1.
- R2: Activate to an idle bank moves it to row open. The bank's field in `bank_state_o` becomes 1 and the action is 3. Activate to a bank that is not idle is illegal.
- R3: Read or write to an idle bank is illegal.
- R4: Mode set (action 1) and refresh (action 2) are legal only when every bank is idle. Otherwise they are illegal.
- R5: Read or write to an open bank starts a burst: state 2, action 5.
  - The burst lasts `burst_len_i` cycles, with 0 counted as 1.
  - The bank then returns to row open (state 1) when bit 10 was low.
- R6: A read or write with `a10_i` high returns the bank to idle (state 0) when its burst expires.
- R7: Read or write to a bank in a burst ends that burst and starts a new one (action 6). The new burst uses the new length and the new auto-precharge choice.
- R8: Precharge with `a10_i` low closes the addressed bank to idle from any state, idle included. The action is 4.
- R9: Precharge with `a10_i` high closes every bank to idle.
- R10: No operation and deselect are legal (action 0). Running bursts keep counting down through them.
- R11: An illegal command raises `illegal_o` for the one cycle of its result and sets the action to 7. No bank state and no countdown changes in that cycle.
- R12: After reset every bank is idle, `cmd_o` is 0, the action is 0 and `illegal_o` is low.
- Field encoding: bank b occupies bits [2b+1:2b] of `bank_state_o`, with 0 = idle, 1 = row open, 2 = burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | BA_W (2) | Bank address |
| a10_i | input | 1 | Auto precharge on read/write; all-bank select on precharge |
| burst_len_i | input | BL_W (10) | Burst length loaded on read/write |
| cmd_o | output | 3 | Decoded command code |
| action_o | output | 3 | Action taken for the command |
| illegal_o | output | 1 | Command was illegal |
| bank_state_o | output | 2*NUM_BANKS | Packed state of every bank |

## Verification
The bench targets four corner cases:
- A read or write landing on a burst in the same cycle its count would expire. A design that let the expiry win would report row open instead of a restarted burst.
- An illegal activate during a running burst. A design that kept counting during the rejected cycle would end the burst one cycle early.
- A burst length of zero. Mishandling it would either wrap the countdown and hang the bank in burst, or end before one cycle.
- A precharge to an already idle bank, and a precharge to all banks with some still open. A design that flagged the first, or closed only the addressed bank on the second, is caught by the per-cycle comparison of every bank field.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;
  typedef enum logic [2:0] {
    CMD_DESEL = 3'd0, CMD_NOP = 3'd1, CMD_MRS = 3'd2, CMD_REF = 3'd3,
    CMD_PRE   = 3'd4, CMD_ACT = 3'd5, CMD_WR  = 3'd6, CMD_RD  = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0, OP_MODE    = 3'd1, OP_REFRESH = 3'd2, OP_OPEN   = 3'd3,
    OP_CLOSE = 3'd4, OP_BURST   = 3'd5, OP_RESTART = 3'd6, OP_REJECT = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    BANK_IDLE = 2'd0, BANK_OPEN = 2'd1, BANK_BURST = 2'd2
  } bank_st_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_chk_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    if (cs_ni) begin
      cmd_o = CMD_DESEL;
    end else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b000:  cmd_o = CMD_MRS;
        3'b001:  cmd_o = CMD_REF;
        3'b010:  cmd_o = CMD_PRE;
        3'b011:  cmd_o = CMD_ACT;
        3'b100:  cmd_o = CMD_WR;
        3'b101:  cmd_o = CMD_RD;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdram_cmd_judge.sv
module sdram_cmd_judge
  import sdram_chk_pkg::*;
(
  input  cmd_e     cmd_i,
  input  bank_st_e addr_st_i,
  input  logic     all_idle_i,
  output logic     reject_o,
  output op_e      op_o
);
  op_e op_raw;
  logic ok;

  always_comb begin
    ok     = 1'b1;
    op_raw = OP_NONE;
    unique case (cmd_i)
      CMD_MRS: begin ok = all_idle_i; op_raw = OP_MODE;    end
      CMD_REF: begin ok = all_idle_i; op_raw = OP_REFRESH; end
      CMD_PRE: op_raw = OP_CLOSE;
      CMD_ACT: begin ok = (addr_st_i == BANK_IDLE); op_raw = OP_OPEN; end
      CMD_WR, CMD_RD: begin
        ok     = (addr_st_i != BANK_IDLE);
        op_raw = (addr_st_i == BANK_BURST) ? OP_RESTART : OP_BURST;
      end
      default: op_raw = OP_NONE;
    endcase
    reject_o = !ok;
    op_o     = ok ? op_raw : OP_REJECT;
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_chk_pkg::*;
#(
  parameter int BA_W = 2,
  parameter int BL_W = 10,
  parameter int IDX  = 0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  cmd_e            cmd_i,
  input  logic [BA_W-1:0] ba_i,
  input  logic            a10_i,
  input  logic            reject_i,
  input  logic [BL_W-1:0] burst_len_i,
  output bank_st_e        state_o
);
  bank_st_e        st_q, st_d;
  logic [BL_W-1:0] cnt_q, cnt_d;
  logic            ap_q, ap_d;
  logic            hit;

  assign hit = (ba_i == BA_W'(IDX));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    ap_d  = ap_q;
    if (!reject_i) begin
      // background countdown
      if (st_q == BANK_BURST) begin
        if (cnt_q <= BL_W'(1)) st_d = ap_q ? BANK_IDLE : BANK_OPEN;
        else                   cnt_d = cnt_q - BL_W'(1);
      end
      // command to this bank overrides the countdown
      unique case (cmd_i)
        CMD_PRE: if (a10_i || hit) begin
          st_d  = BANK_IDLE;
          cnt_d = '0;
          ap_d  = 1'b0;
        end
        CMD_ACT: if (hit) st_d = BANK_OPEN;
        CMD_WR, CMD_RD: if (hit) begin
          st_d  = BANK_BURST;
          cnt_d = (burst_len_i == '0) ? BL_W'(1) : burst_len_i;
          ap_d  = a10_i;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BANK_IDLE;
      cnt_q <= '0;
      ap_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ap_q  <= ap_d;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
  import sdram_chk_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  parameter  int BL_W      = 10,
  localparam int BA_W      = $clog2(NUM_BANKS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_ni,
  input  logic                   ras_ni,
  input  logic                   cas_ni,
  input  logic                   we_ni,
  input  logic [BA_W-1:0]        ba_i,
  input  logic                   a10_i,
  input  logic [BL_W-1:0]        burst_len_i,
  output logic [2:0]             cmd_o,
  output logic [2:0]             action_o,
  output logic                   illegal_o,
  output logic [2*NUM_BANKS-1:0] bank_state_o
);
  cmd_e     cmd;
  op_e      op;
  logic     reject;
  logic     all_idle;
  bank_st_e addr_st;
  bank_st_e st [NUM_BANKS];

  sdram_cmd_decode u_decode (
    .cs_ni (cs_ni),
    .ras_ni(ras_ni),
    .cas_ni(cas_ni),
    .we_ni (we_ni),
    .cmd_o (cmd)
  );

  always_comb begin
    all_idle = 1'b1;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (st[i] != BANK_IDLE) all_idle = 1'b0;
    end
  end

  assign addr_st = st[ba_i];

  sdram_cmd_judge u_judge (
    .cmd_i     (cmd),
    .addr_st_i (addr_st),
    .all_idle_i(all_idle),
    .reject_o  (reject),
    .op_o      (op)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    sdram_bank_track #(
      .BA_W(BA_W),
      .BL_W(BL_W),
      .IDX (g)
    ) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cmd_i      (cmd),
      .ba_i       (ba_i),
      .a10_i      (a10_i),
      .reject_i   (reject),
      .burst_len_i(burst_len_i),
      .state_o    (st[g])
    );
    assign bank_state_o[2*g +: 2] = st[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o     <= CMD_DESEL;
      action_o  <= OP_NONE;
      illegal_o <= 1'b0;
    end else begin
      cmd_o     <= cmd;
      action_o  <= op;
      illegal_o <= reject;
    end
  end
endmodule

// File: rtl/sdram_cmd_checker_sva.sv
module sdram_cmd_checker_sva #(
  parameter  int NUM_BANKS = 4,
  parameter  int BL_W      = 10,
  localparam int BA_W      = $clog2(NUM_BANKS)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cs_ni,
  input logic                   ras_ni,
  input logic                   cas_ni,
  input logic                   we_ni,
  input logic [BA_W-1:0]        ba_i,
  input logic                   a10_i,
  input logic [BL_W-1:0]        burst_len_i,
  input logic [2:0]             cmd_o,
  input logic [2:0]             action_o,
  input logic                   illegal_o,
  input logic [2*NUM_BANKS-1:0] bank_state_o
);
  logic       pin_rw, pin_act, pin_pre, pin_cfg;
  logic [1:0] addr_field;

  assign pin_rw     = !cs_ni && ras_ni && !cas_ni;
  assign pin_act    = !cs_ni && !ras_ni && cas_ni && we_ni;
  assign pin_pre    = !cs_ni && !ras_ni && cas_ni && !we_ni;
  assign pin_cfg    = !cs_ni && !ras_ni && !cas_ni;
  assign addr_field = bank_state_o[{ba_i, 1'b0} +: 2];

  p_deselect_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> cmd_o == 3'd0);

  p_open_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_act && addr_field == 2'd0) |=> bank_state_o[{$past(ba_i), 1'b0} +: 2] == 2'd1);

  p_reopen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_act && addr_field != 2'd0) |=> illegal_o);

  p_rw_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_rw && addr_field == 2'd0) |=> illegal_o);

  p_cfg_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_cfg && bank_state_o != '0) |=> illegal_o);

  p_pre_all_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_pre && a10_i) |=> bank_state_o == '0);

  p_freeze_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ($stable(bank_state_o) && action_o == 3'd7));
endmodule

bind sdram_cmd_checker sdram_cmd_checker_sva #(
  .NUM_BANKS(NUM_BANKS),
  .BL_W     (BL_W)
) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .ras_ni      (ras_ni),
  .cas_ni      (cas_ni),
  .we_ni       (we_ni),
  .ba_i        (ba_i),
  .a10_i       (a10_i),
  .burst_len_i (burst_len_i),
  .cmd_o       (cmd_o),
  .action_o    (action_o),
  .illegal_o   (illegal_o),
  .bank_state_o(bank_state_o)
);

// File: tb/sdram_cmd_checker_test.sv
`timescale 1ns/1ps
module sdram_cmd_checker_test;
  localparam int NB   = 4;
  localparam int BL_W = 10;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cs_ni = 1'b1, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1;
  logic [1:0]    ba_i = '0;
  logic          a10_i = 1'b0;
  logic [BL_W-1:0] burst_len_i = '0;
  logic [2:0]    cmd_o, action_o;
  logic          illegal_o;
  logic [2*NB-1:0] bank_state_o;

  always #10 clk = ~clk;

  sdram_cmd_checker #(.NUM_BANKS(NB), .BL_W(BL_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .ras_ni(ras_ni),
    .cas_ni(cas_ni), .we_ni(we_ni), .ba_i(ba_i), .a10_i(a10_i),
    .burst_len_i(burst_len_i), .cmd_o(cmd_o), .action_o(action_o),
    .illegal_o(illegal_o), .bank_state_o(bank_state_o)
  );

  int total = 0, bad = 0;
  bit done = 0;
  // reference model: 0 idle, 1 open, 2 burst
  int m_st [NB];
  int m_cnt[NB];
  int m_ap [NB];
  int e_cmd = 0, e_act = 0, e_ill = 0;

  localparam int DES = 0, NOP = 1, MRS = 2, REF = 3, PRE = 4, ACT = 5, WR = 6, RD = 7, ODD = 8;

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d t=%0t", req, what, got, exp, $time);
    end
  endtask

  task automatic compare(input string req);
    chk(req, "cmd", int'(cmd_o), e_cmd);
    chk(req, "action", int'(action_o), e_act);
    chk(req, "illegal", int'(illegal_o), e_ill);
    for (int b = 0; b < NB; b++) chk(req, $sformatf("bank%0d", b), int'(bank_state_o[2*b +: 2]), m_st[b]);
  endtask

  task automatic model(input int code, input int ba, input int a10, input int bl);
    bit all_idle = 1;
    bit ok = 1;
    int act = 0;
    int st_a = m_st[ba];
    for (int b = 0; b < NB; b++) if (m_st[b] != 0) all_idle = 0;
    case (code)
      MRS: begin ok = all_idle; act = 1; end
      REF: begin ok = all_idle; act = 2; end
      PRE: act = 4;
      ACT: begin ok = (st_a == 0); act = 3; end
      WR, RD: begin ok = (st_a != 0); act = (st_a == 2) ? 6 : 5; end
      default: act = 0;
    endcase
    e_cmd = code;
    e_act = ok ? act : 7;
    e_ill = ok ? 0 : 1;
    if (ok) begin
      for (int b = 0; b < NB; b++) begin
        if (code == PRE && (a10 != 0 || b == ba)) begin
          m_st[b] = 0; m_cnt[b] = 0; m_ap[b] = 0;
        end else if (code == ACT && b == ba) begin
          m_st[b] = 1;
        end else if ((code == WR || code == RD) && b == ba) begin
          m_st[b] = 2; m_cnt[b] = (bl == 0) ? 1 : bl; m_ap[b] = a10;
        end else if (m_st[b] == 2) begin
          if (m_cnt[b] <= 1) m_st[b] = (m_ap[b] != 0) ? 0 : 1;
          else m_cnt[b] = m_cnt[b] - 1;
        end
      end
    end
  endtask

  task automatic step(input string req, input int code, input int ba = 0, input int a10 = 0, input int bl = 1);
    logic [3:0] pins;
    int mcode;
    case (code)
      DES: pins = 4'b1111;
      NOP: pins = 4'b0111;
      MRS: pins = 4'b0000;
      REF: pins = 4'b0001;
      PRE: pins = 4'b0010;
      ACT: pins = 4'b0011;
      WR:  pins = 4'b0100;
      RD:  pins = 4'b0101;
      default: pins = 4'b0110;
    endcase
    mcode = (code == ODD) ? NOP : code;
    {cs_ni, ras_ni, cas_ni, we_ni} = pins;
    ba_i = 2'(ba);
    a10_i = a10[0];
    burst_len_i = BL_W'(bl);
    model(mcode, ba, a10, bl);
    @(posedge clk);
    #1;
    compare(req);
    @(negedge clk);
  endtask

  task automatic nops(input string req, input int n);
    for (int i = 0; i < n; i++) step(req, NOP);
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin m_st[b] = 0; m_cnt[b] = 0; m_ap[b] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R12");

    step("R1", DES);
    step("R10", NOP);
    step("R1", ODD);
    step("R3", RD, 0);
    step("R11", NOP);
    step("R3", WR, 2);
    step("R4", MRS);
    step("R4", REF);
    step("R2", ACT, 0);
    step("R2", ACT, 0);
    step("R4", MRS);
    step("R4", REF);
    step("R5", WR, 0, 0, 4);
    nops("R5", 5);
    step("R6", RD, 0, 1, 3);
    nops("R6", 4);
    step("R2", ACT, 1);
    step("R2", ACT, 2);
    step("R5", RD, 1, 0, 8);
    nops("R10", 2);
    step("R7", RD, 1, 0, 2);
    nops("R7", 3);
    // restart landing on the expiry cycle
    step("R7", WR, 1, 0, 2);
    step("R7", NOP);
    step("R7", RD, 1, 1, 3);
    nops("R7", 4);
    step("R2", ACT, 1);
    step("R6", RD, 2, 1, 5);
    step("R10", DES);
    step("R8", PRE, 2, 0);
    step("R8", PRE, 3, 0);
    step("R2", ACT, 3);
    step("R5", WR, 3, 0, 6);
    step("R10", NOP);
    step("R11", ACT, 3);
    step("R11", RD, 0);
    nops("R11", 6);
    step("R2", ACT, 0);
    step("R9", PRE, 2, 1);
    step("R2", ACT, 0);
    step("R5", RD, 0, 0, 0);
    nops("R5", 2);
    step("R8", PRE, 0, 0);
    step("R1", MRS);
    step("R1", REF);
    step("R1", PRE, 1, 0);
    step("R1", ACT, 1);
    step("R1", WR, 1, 0, 1);
    step("R1", RD, 1, 0, 1);
    step("R1", ODD);
    nops("R10", 2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule